// File: doc/BRIEF.md
# Debug instruction and data transfer controller

This block sits between a JTAG-style test access port controller and a processor core that has halted in debug state. The TAP controller hands it one-cycle event strobes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle. It also supplies the active TAP instruction (EXTEST or INTEST) and a chain select that picks either the instruction chain or the data chain. The block owns both 33-bit scan chains, an instruction holding register, a debugger-to-core data register and a core-to-debugger data register.

A debugger scans an instruction into the holding register, stores data for the core, and walks the TAP through Run-Test/Idle to issue the instruction. It then polls a completion flag that comes back in bit 0 of every captured chain. A snapshot of that flag, taken at Capture-DR and called Ready, gates all register loads and all issue. Two sticky abort flags behave differently. The precise one stops execution and pins the completion flag high, so that later issue attempts look successful but do nothing. The imprecise one is only recorded.

Top module: `dbg_xfer_ctrl`

## Requirements
- R1: After reset, instr_complete is 1; ready, both sticky flags, core_issue, tdo, core_instr and core_rd_data are 0.
- R2: On tap_capture, ready takes the value instr_complete had before that edge. Bit 0 of the selected chain takes the same value. When ir_extest or ir_intest is high, chain bits 32:1 load the core-to-debugger register (data chain, chain_sel=1) or the held instruction (instruction chain, chain_sel=0).
- R3: On tap_shift, the selected chain shifts one place toward bit 0 and tdi enters bit 32. tdo always shows bit 0 of the selected chain. The chain that is not selected keeps its contents.
- R4: On tap_update, with ir_extest and ready both high, chain bits 32:1 load the held instruction when chain_sel=0, or core_rd_data when chain_sel=1.
- R5: When ready is 0, or ir_extest is 0, tap_update leaves both the held instruction and core_rd_data unchanged.
- R6: On tap_idle, with ready, exec_en and not sticky_precise, core_issue pulses for one cycle after the edge, carrying the held instruction on core_instr, and instr_complete goes to 0. When exec_en is 0 or ready is 0, no issue occurs.
- R7: A core_done pulse sets instr_complete to 1.
- R8: core_abort_precise sets sticky_precise. While sticky_precise is set, instr_complete stays 1 and tap_idle issues nothing.
- R9: core_abort_imprecise sets sticky_imprecise, and instructions still issue while it is set.
- R10: Both sticky flags hold until abort_clr or reset clears them. When a set and a clear arrive together, the set wins.
- R11: A core_wr_valid pulse loads core_wr_data into the core-to-debugger register, and the next data-chain capture reads it out.
- R12: When tap_capture and core_done arrive in the same cycle, ready and captured bit 0 read 0, while instr_complete becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_capture | input | 1 | Capture-DR strobe |
| tap_shift | input | 1 | Shift-DR strobe, one bit per cycle |
| tap_update | input | 1 | Update-DR strobe |
| tap_idle | input | 1 | Run-Test/Idle strobe |
| ir_extest | input | 1 | EXTEST instruction active |
| ir_intest | input | 1 | INTEST instruction active |
| chain_sel | input | 1 | 0 = instruction chain, 1 = data chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected chain |
| exec_en | input | 1 | Execute-instruction enable |
| abort_clr | input | 1 | Clears both sticky abort flags |
| core_issue | output | 1 | One-cycle instruction issue pulse |
| core_instr | output | 32 | Held instruction |
| core_rd_data | output | 32 | Debugger-to-core data register |
| core_wr_valid | input | 1 | Core writes the core-to-debugger register |
| core_wr_data | input | 32 | Data written by the core |
| core_done | input | 1 | Core finished the issued instruction |
| core_abort_precise | input | 1 | Precise data abort from the core |
| core_abort_imprecise | input | 1 | Imprecise data abort from the core |
| instr_complete | output | 1 | Instruction-complete flag |
| ready | output | 1 | Copy of instr_complete taken at capture |
| sticky_precise | output | 1 | Sticky precise abort flag |
| sticky_imprecise | output | 1 | Sticky imprecise abort flag |

## Verification
Completion of a running instruction and a Capture-DR can land in the same cycle. The snapshot must then take the pre-edge flag, while the flag itself rises. The bench raises core_done and tap_capture on the same clock. It then checks that ready is 0 and instr_complete is 1. It also checks that the bit 0 shifted out of the chain afterwards is 0, and that a following update is blocked. Issued instructions are predicted in a queue before each Run-Test/Idle. A monitor matches every issue pulse against that queue, so a suppressed issue or a stray one is caught.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;

    typedef enum logic {
        CHAIN_INSTR = 1'b0,
        CHAIN_DATA  = 1'b1
    } chain_e;

    typedef struct packed {
        logic precise;
        logic imprecise;
    } abort_t;

    // Capture is allowed only under a boundary-test instruction
    function automatic logic capture_permitted(input logic extest, input logic intest);
        return extest | intest;
    endfunction

    // Register loads at update need EXTEST and a set Ready snapshot
    function automatic logic update_permitted(input logic extest, input logic rdy);
        return extest & rdy;
    endfunction

endpackage

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
    parameter int PAYLOAD_W = 32,
    localparam int CHAIN_W  = PAYLOAD_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_me,
    input  logic                 capture,
    input  logic                 cap_ok,
    input  logic                 shift,
    input  logic                 tdi,
    input  logic                 flag_in,
    input  logic [PAYLOAD_W-1:0] payload_in,
    output logic [CHAIN_W-1:0]   chain_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (sel_me && capture) begin
            chain_q[0] <= flag_in;
            if (cap_ok) begin
                chain_q[CHAIN_W-1:1] <= payload_in;
            end
        end else if (sel_me && shift) begin
            chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
        end
    end

    // R3: serial input lands at the far end of the chain
    a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
        (sel_me && shift && !capture) |=> chain_q[CHAIN_W-1] == $past(tdi));

    // R3: a chain that is not selected keeps its bits
    a_r3_unselected_holds: assert property (@(posedge clk) disable iff (rst)
        !sel_me |=> $stable(chain_q));

endmodule

// File: rtl/dbg_xfer_regs.sv
module dbg_xfer_regs
    import dbg_xfer_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic                 update,
    input  logic                 extest,
    input  chain_e               sel,
    input  logic                 complete,
    input  logic [PAYLOAD_W-1:0] instr_payload,
    input  logic [PAYLOAD_W-1:0] data_payload,
    input  logic                 wr_valid,
    input  logic [PAYLOAD_W-1:0] wr_data,
    output logic                 ready,
    output logic [PAYLOAD_W-1:0] held_instr,
    output logic [PAYLOAD_W-1:0] to_core,
    output logic [PAYLOAD_W-1:0] to_dbg
);

    logic load_ok;
    assign load_ok = update && update_permitted(extest, ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready      <= 1'b0;
            held_instr <= '0;
            to_core    <= '0;
            to_dbg     <= '0;
        end else begin
            if (capture) begin
                ready <= complete;
            end
            if (load_ok) begin
                if (sel == CHAIN_INSTR) begin
                    held_instr <= instr_payload;
                end else begin
                    to_core <= data_payload;
                end
            end
            if (wr_valid) begin
                to_dbg <= wr_data;
            end
        end
    end

    // R5: a clear snapshot blocks every update load
    a_r5_hold_when_not_ready: assert property (@(posedge clk) disable iff (rst)
        (update && !ready) |=> ($stable(held_instr) && $stable(to_core)));

    // R2: the snapshot equals the flag value seen at capture
    a_r2_ready_snapshot: assert property (@(posedge clk) disable iff (rst)
        capture |=> ready == $past(complete));

endmodule

// File: rtl/dbg_exec_ctrl.sv
module dbg_exec_ctrl
    import dbg_xfer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   idle,
    input  logic   ready,
    input  logic   exec_en,
    input  logic   done,
    input  abort_t abort_in,
    input  logic   abort_clr,
    output logic   complete,
    output logic   issue,
    output abort_t sticky
);

    logic fire;
    assign fire = idle && ready && exec_en && !sticky.precise;

    always_ff @(posedge clk) begin
        if (rst) begin
            complete <= 1'b1;
            issue    <= 1'b0;
            sticky   <= '0;
        end else begin
            issue <= fire;

            if (abort_in.precise) begin
                sticky.precise <= 1'b1;
            end else if (abort_clr) begin
                sticky.precise <= 1'b0;
            end

            if (abort_in.imprecise) begin
                sticky.imprecise <= 1'b1;
            end else if (abort_clr) begin
                sticky.imprecise <= 1'b0;
            end

            if (abort_in.precise || sticky.precise) begin
                complete <= 1'b1;
            end else if (fire) begin
                complete <= 1'b0;
            end else if (done) begin
                complete <= 1'b1;
            end
        end
    end

    // R8: precise abort pins the completion flag high
    a_r8_complete_pinned: assert property (@(posedge clk) disable iff (rst)
        sticky.precise |-> complete);

    // R8: no issue follows a cycle with the precise flag set
    a_r8_no_issue: assert property (@(posedge clk) disable iff (rst)
        sticky.precise |=> !issue);

    // R6: a permitted idle issues and drops the completion flag
    a_r6_issue_clears_complete: assert property (@(posedge clk) disable iff (rst)
        (idle && ready && exec_en && !sticky.precise && !abort_in.precise)
            |=> (issue && !complete));

    // R10: sticky flags hold without a clear
    a_r10_precise_sticky: assert property (@(posedge clk) disable iff (rst)
        (sticky.precise && !abort_clr) |=> sticky.precise);

    a_r10_imprecise_sticky: assert property (@(posedge clk) disable iff (rst)
        (sticky.imprecise && !abort_clr) |=> sticky.imprecise);

endmodule

// File: rtl/dbg_xfer_ctrl.sv
module dbg_xfer_ctrl
    import dbg_xfer_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tap_capture,
    input  logic                 tap_shift,
    input  logic                 tap_update,
    input  logic                 tap_idle,
    input  logic                 ir_extest,
    input  logic                 ir_intest,
    input  logic                 chain_sel,
    input  logic                 tdi,
    output logic                 tdo,
    input  logic                 exec_en,
    input  logic                 abort_clr,
    output logic                 core_issue,
    output logic [PAYLOAD_W-1:0] core_instr,
    output logic [PAYLOAD_W-1:0] core_rd_data,
    input  logic                 core_wr_valid,
    input  logic [PAYLOAD_W-1:0] core_wr_data,
    input  logic                 core_done,
    input  logic                 core_abort_precise,
    input  logic                 core_abort_imprecise,
    output logic                 instr_complete,
    output logic                 ready,
    output logic                 sticky_precise,
    output logic                 sticky_imprecise
);

    localparam int CHAIN_W = PAYLOAD_W + 1;
    localparam int NCHAIN  = 2;

    chain_e                             sel;
    logic                               cap_ok;
    logic [NCHAIN-1:0]                  sel_me;
    logic [NCHAIN-1:0][PAYLOAD_W-1:0]   cap_pay;
    logic [NCHAIN-1:0][CHAIN_W-1:0]     chain_q;
    logic [PAYLOAD_W-1:0]               held_instr;
    logic [PAYLOAD_W-1:0]               to_dbg;
    abort_t                             abort_in;
    abort_t                             sticky;

    assign sel      = chain_e'(chain_sel);
    assign cap_ok   = capture_permitted(ir_extest, ir_intest);
    assign cap_pay[CHAIN_INSTR] = held_instr;
    assign cap_pay[CHAIN_DATA]  = to_dbg;
    assign abort_in = '{precise: core_abort_precise, imprecise: core_abort_imprecise};

    for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
        assign sel_me[c] = (chain_sel == 1'(c));

        dbg_scan_chain #(.PAYLOAD_W(PAYLOAD_W)) u_chain (
            .clk        (clk),
            .rst        (rst),
            .sel_me     (sel_me[c]),
            .capture    (tap_capture),
            .cap_ok     (cap_ok),
            .shift      (tap_shift),
            .tdi        (tdi),
            .flag_in    (instr_complete),
            .payload_in (cap_pay[c]),
            .chain_q    (chain_q[c])
        );
    end

    assign tdo = chain_q[chain_sel][0];

    dbg_xfer_regs #(.PAYLOAD_W(PAYLOAD_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .capture       (tap_capture),
        .update        (tap_update),
        .extest        (ir_extest),
        .sel           (sel),
        .complete      (instr_complete),
        .instr_payload (chain_q[CHAIN_INSTR][CHAIN_W-1:1]),
        .data_payload  (chain_q[CHAIN_DATA][CHAIN_W-1:1]),
        .wr_valid      (core_wr_valid),
        .wr_data       (core_wr_data),
        .ready         (ready),
        .held_instr    (held_instr),
        .to_core       (core_rd_data),
        .to_dbg        (to_dbg)
    );

    dbg_exec_ctrl u_exec (
        .clk       (clk),
        .rst       (rst),
        .idle      (tap_idle),
        .ready     (ready),
        .exec_en   (exec_en),
        .done      (core_done),
        .abort_in  (abort_in),
        .abort_clr (abort_clr),
        .complete  (instr_complete),
        .issue     (core_issue),
        .sticky    (sticky)
    );

    assign core_instr       = held_instr;
    assign sticky_precise   = sticky.precise;
    assign sticky_imprecise = sticky.imprecise;

    // R12: a capture that meets core_done sees the old flag
    a_r12_capture_vs_done: assert property (@(posedge clk) disable iff (rst)
        (tap_capture && core_done && !instr_complete) |=> (!ready && instr_complete));

    // R6: issue pulses last exactly one cycle without a new idle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (core_issue && !tap_idle) |=> !core_issue);

endmodule

// File: tb/test_dbg_xfer_ctrl.sv
module test_dbg_xfer_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tap_capture = 0, tap_shift = 0, tap_update = 0, tap_idle = 0;
    logic        ir_extest = 0, ir_intest = 0, chain_sel = 0, tdi = 0;
    logic        tdo;
    logic        exec_en = 0, abort_clr = 0;
    logic        core_issue;
    logic [31:0] core_instr, core_rd_data;
    logic        core_wr_valid = 0;
    logic [31:0] core_wr_data = '0;
    logic        core_done = 0, core_abort_precise = 0, core_abort_imprecise = 0;
    logic        instr_complete, ready, sticky_precise, sticky_imprecise;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_item;
    logic [32:0] dout;

    always #2 clk = ~clk;

    dbg_xfer_ctrl i_dbg_xfer_ctrl (.*);

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every issue pulse must match the next predicted instruction
    always @(negedge clk) begin
        if (!rst && core_issue) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6 actual=issue %h expected=no issue", core_instr);
            end else begin
                exp_item = exp_q.pop_front();
                if (core_instr !== exp_item) begin
                    fails++;
                    $display("FAIL R6 actual=%h expected=%h", core_instr, exp_item);
                end
            end
        end
    end

    task automatic shift_bits(input logic [32:0] din, output logic [32:0] dq);
        for (int i = 0; i < 33; i++) begin
            dq[i] = tdo;
            tdi = din[i];
            tap_shift = 1'b1;
            @(negedge clk);
        end
        tap_shift = 1'b0;
    endtask

    task automatic scan(input logic sel, input logic ext, input logic intst,
                        input logic [32:0] din, output logic [32:0] dq);
        @(negedge clk);
        chain_sel = sel; ir_extest = ext; ir_intest = intst; tap_capture = 1'b1;
        @(negedge clk);
        tap_capture = 1'b0;
        shift_bits(din, dq);
        tap_update = 1'b1;
        @(negedge clk);
        tap_update = 1'b0;
    endtask

    task automatic idle_pulse();
        @(negedge clk) tap_idle = 1'b1;
        @(negedge clk) tap_idle = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk) core_done = 1'b1;
        @(negedge clk) core_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 complete", instr_complete, 1);
        check("R1 ready", ready, 0);
        check("R1 sticky", {sticky_precise, sticky_imprecise}, 0);
        check("R1 issue", core_issue, 0);
        check("R1 tdo", tdo, 0);
        check("R1 instr", core_instr, 0);
        check("R1 rd_data", core_rd_data, 0);

        // R5: update with ready still clear after reset is ignored
        ir_extest = 1'b1; chain_sel = 1'b0;
        @(negedge clk);
        shift_bits({32'h1111_2222, 1'b0}, dout);
        tap_update = 1'b1;
        @(negedge clk) tap_update = 1'b0;
        check("R5 not ready instr", core_instr, 0);

        // R2/R4: instruction chain load
        scan(1'b0, 1'b1, 1'b0, {32'hA5A5_0001, 1'b0}, dout);
        check("R2 capture instr chain", dout, {32'h0, 1'b1});
        check("R4 instr load", core_instr, 32'hA5A5_0001);
        check("R2 ready", ready, 1);

        // R4: data chain load
        scan(1'b1, 1'b1, 1'b0, {32'hD00D_F00D, 1'b0}, dout);
        check("R2 capture data chain", dout, {32'h0, 1'b1});
        check("R4 data load", core_rd_data, 32'hD00D_F00D);

        // R3: instruction chain kept its last shifted contents
        @(negedge clk) chain_sel = 1'b0;
        shift_bits({32'h0, 1'b0}, dout);
        check("R3 unselected chain held", dout, {32'hA5A5_0001, 1'b0});

        // R11/R2/R5: core write read back under INTEST, update ignored
        @(negedge clk) begin core_wr_valid = 1'b1; core_wr_data = 32'hCAFE_1234; end
        @(negedge clk) core_wr_valid = 1'b0;
        scan(1'b1, 1'b0, 1'b1, {32'hFFFF_FFFF, 1'b0}, dout);
        check("R11 core write readout", dout, {32'hCAFE_1234, 1'b1});
        check("R5 intest no load", core_rd_data, 32'hD00D_F00D);

        // R6: disabled execution issues nothing
        exec_en = 1'b0;
        idle_pulse();
        check("R6 disabled no issue", core_issue, 0);
        check("R6 disabled complete", instr_complete, 1);

        // R6: permitted issue
        exec_en = 1'b1;
        exp_q.push_back(32'hA5A5_0001);
        idle_pulse();
        check("R6 issue pulse", core_issue, 1);
        check("R6 complete cleared", instr_complete, 0);

        // R5: busy core, capture gives ready=0, load blocked, no issue
        scan(1'b0, 1'b1, 1'b0, {32'hBBBB_0002, 1'b0}, dout);
        check("R2 busy flag bit", dout, {32'hA5A5_0001, 1'b0});
        check("R5 busy instr held", core_instr, 32'hA5A5_0001);
        idle_pulse();
        check("R6 not ready no issue", core_issue, 0);

        // R12: capture coincides with core_done
        @(negedge clk) begin chain_sel = 1'b0; tap_capture = 1'b1; core_done = 1'b1; end
        @(negedge clk) begin tap_capture = 1'b0; core_done = 1'b0; end
        check("R12 ready old value", ready, 0);
        check("R7 complete set", instr_complete, 1);
        shift_bits({32'hBBBB_0002, 1'b0}, dout);
        check("R12 captured bit0", dout[0], 0);
        tap_update = 1'b1;
        @(negedge clk) tap_update = 1'b0;
        check("R12 update blocked", core_instr, 32'hA5A5_0001);

        // Fresh capture now sees completion
        scan(1'b0, 1'b1, 1'b0, {32'hBBBB_0002, 1'b0}, dout);
        check("R4 reload", core_instr, 32'hBBBB_0002);
        exp_q.push_back(32'hBBBB_0002);
        idle_pulse();
        check("R6 second issue complete", instr_complete, 0);

        // R8: precise abort
        @(negedge clk) core_abort_precise = 1'b1;
        @(negedge clk) core_abort_precise = 1'b0;
        check("R8 sticky set", sticky_precise, 1);
        check("R8 complete forced", instr_complete, 1);
        scan(1'b0, 1'b1, 1'b0, {32'hCCCC_0003, 1'b0}, dout);
        idle_pulse();
        check("R8 no issue", core_issue, 0);
        check("R8 complete stays", instr_complete, 1);
        check("R10 precise held", sticky_precise, 1);

        // R10: clear
        @(negedge clk) abort_clr = 1'b1;
        @(negedge clk) abort_clr = 1'b0;
        check("R10 precise cleared", sticky_precise, 0);

        // R9: imprecise abort does not stop issue
        @(negedge clk) core_abort_imprecise = 1'b1;
        @(negedge clk) core_abort_imprecise = 1'b0;
        check("R9 imprecise set", sticky_imprecise, 1);
        exp_q.push_back(32'hCCCC_0003);
        idle_pulse();
        check("R9 issue under imprecise", core_issue, 1);
        done_pulse();
        check("R10 imprecise held", sticky_imprecise, 1);

        // R10: set wins over clear
        @(negedge clk) begin abort_clr = 1'b1; core_abort_imprecise = 1'b1; end
        @(negedge clk) begin abort_clr = 1'b0; core_abort_imprecise = 1'b0; end
        check("R10 set wins", sticky_imprecise, 1);
        @(negedge clk) abort_clr = 1'b1;
        @(negedge clk) abort_clr = 1'b0;
        check("R10 imprecise cleared", sticky_imprecise, 0);

        repeat (2) @(negedge clk);
        check("R6 all predicted issues seen", exp_q.size(), 0);
        finish_run();
    end

endmodule